// File: doc/BRIEF.md
# Per-DIMM Transaction Rate Throttler

This block caps the memory power drawn by each DIMM slot on a channel by bounding how many power-relevant commands that slot may receive within a fixed one-microsecond window. It watches a command-issue strobe from the scheduler. Each strobe carries a command kind and the index of the DIMM it targets. Activate, read and write commands are tallied per DIMM. All other command kinds pass without being counted.

A shared timer counts clock cycles and closes a window every `CYC_PER_US` cycles. All per-DIMM tallies clear when a new window begins. Each DIMM has a transaction budget and a throttle-enable flag. While the flag is set and the tally has reached the budget, a per-DIMM hold line tells the scheduler to stop issuing counted commands to that DIMM. The hold line stays up until the window closes.

Firmware can rewrite a DIMM's budget and enable flag through a one-cycle write strobe at any moment, including in mid-window. The new setting acts on the hold line one cycle after the write.

Top module: `dimm_rate_throttle`

## Requirements
- R1: While `rst_n` is low, every hold line is low, every budget is all ones (4095 for the default 12-bit width) and every enable flag is 1. The first window begins at the second rising edge at which `rst_n` is sampled high.
- R2: A strobe counts only when `cmd_kind` is 1 (activate), 2 (read) or 3 (write). Kinds 0 and 4 to 7 never change any tally. A kind presented with `cmd_vld` low is also not counted.
- R3: A counted command adds one to the tally of the DIMM named by `cmd_dimm` only. A `cmd_dimm` value of `NUM_DIMMS` or above counts for no DIMM.
- R4: `dimm_hold[i]` is high in the cycle after the command that brings DIMM i's tally up to its budget, provided the enable flag is set. It is low while the tally is below the budget.
- R5: Each window lasts `CYC_PER_US` cycles. In the first cycle of every window, all tallies are zero, so every hold line with a nonzero budget is low. A command issued in the last cycle of a window counts only toward that window.
- R6: While a DIMM's enable flag is 0, its hold line is low whatever its tally. Setting the flag again raises the hold line at once if the tally is already at or above the budget.
- R7: If a budget is rewritten to a value below the current tally, the hold line rises in the cycle after the write and stays high until the window ends.
- R8: A budget of 0 with the flag set holds that DIMM high for every cycle, including across window boundaries.
- R9: A tally saturates at all ones. Further counted commands leave it there and never wrap it to zero.
- R10: A write with `cfg_we` high sets the budget to `cfg_limit` and the flag to `cfg_en`, for the DIMM selected by `cfg_sel` only. A `cfg_sel` of `NUM_DIMMS` or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | Command-issue strobe |
| cmd_kind | input | 3 | Command kind: 1 activate, 2 read, 3 write, others not counted |
| cmd_dimm | input | SEL_W | Target DIMM index of the command |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | DIMM index being configured |
| cfg_en | input | 1 | New throttle-enable flag |
| cfg_limit | input | LIM_W | New transaction budget |
| dimm_hold | output | NUM_DIMMS | Per-DIMM hold request to the scheduler |

## Verification
A tally that misses a command, or that counts one it should ignore, shifts the rise of a hold line by one cycle or more. This is seen at the port within the same window. A tally that is not cleared at the boundary keeps a hold line up into the first cycle of the next window. A misplaced timer moves that drop to a different cycle. A tally that wraps instead of saturating drops the hold line in mid-window on the command after the all-ones value. A budget or flag written to the wrong slot shows on a different hold bit in the cycle after the write.

// File: rtl/dthr_pkg.sv
package dthr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_ZQC = 3'd6,
    CMD_MRS = 3'd7
  } cmd_kind_e;

  // Only row opens and column accesses draw the power being budgeted.
  function automatic logic counts_against_budget(input logic [2:0] kind);
    logic hit;
    case (cmd_kind_e'(kind))
      CMD_ACT, CMD_RD, CMD_WR: hit = 1'b1;
      default:                 hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dthr_rst_sync.sv
module dthr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/dthr_us_timer.sv
module dthr_us_timer #(
  parameter int CYC_PER_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);

  localparam int TW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [TW-1:0] LAST = TW'(CYC_PER_US - 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] tmr_d;
  logic          at_last;

  always_comb begin
    at_last = (tmr_q == LAST);
    tmr_d   = at_last ? '0 : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  assign win_end = at_last;

endmodule

// File: rtl/dthr_cfg_bank.sv
module dthr_cfg_bank #(
  parameter int NUM_DIMMS = 3,
  parameter int LIM_W     = 12,
  parameter int SEL_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic                            cfg_en,
  input  logic [LIM_W-1:0]                cfg_limit,
  output logic [NUM_DIMMS-1:0][LIM_W-1:0] lim_o,
  output logic [NUM_DIMMS-1:0]            en_o
);

  for (genvar g = 0; g < NUM_DIMMS; g++) begin : g_slot
    logic             wr_ce;
    logic [LIM_W-1:0] lim_q;
    logic [LIM_W-1:0] lim_d;
    logic             en_q;
    logic             en_d;

    always_comb begin
      wr_ce = cfg_we && (cfg_sel == SEL_W'(g));
      lim_d = cfg_limit;
      en_d  = cfg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q <= '1;
        en_q  <= 1'b1;
      end else if (wr_ce) begin
        lim_q <= lim_d;
        en_q  <= en_d;
      end
    end

    assign lim_o[g] = lim_q;
    assign en_o[g]  = en_q;
  end

endmodule

// File: rtl/dthr_dimm_ctr.sv
module dthr_dimm_ctr #(
  parameter int LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             win_end,
  input  logic [LIM_W-1:0] limit,
  input  logic             en,
  output logic [LIM_W-1:0] cnt_o,
  output logic             hold_o
);

  localparam logic [LIM_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             cnt_ce;

  // Window close wins over a same-cycle hit: that hit belongs to the old window.
  always_comb begin
    cnt_ce = win_end || (hit && (cnt_q != CNT_MAX));
    cnt_d  = win_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = en && (cnt_q >= limit);

endmodule

// File: rtl/dimm_rate_throttle.sv
module dimm_rate_throttle #(
  parameter int NUM_DIMMS  = 3,
  parameter int CYC_PER_US = 1000,
  parameter int LIM_W      = 12,
  parameter int SEL_W      = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_vld,
  input  logic [2:0]           cmd_kind,
  input  logic [SEL_W-1:0]     cmd_dimm,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic                 cfg_en,
  input  logic [LIM_W-1:0]     cfg_limit,
  output logic [NUM_DIMMS-1:0] dimm_hold
);

  logic                            rst_i;
  logic                            win_end;
  logic                            cmd_counted;
  logic [NUM_DIMMS-1:0]            hit;
  logic [NUM_DIMMS-1:0][LIM_W-1:0] lim;
  logic [NUM_DIMMS-1:0]            en;
  logic [NUM_DIMMS-1:0][LIM_W-1:0] cnt_q;

  dthr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  dthr_us_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_i),
    .win_end (win_end)
  );

  dthr_cfg_bank #(.NUM_DIMMS(NUM_DIMMS), .LIM_W(LIM_W), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_i),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_en    (cfg_en),
    .cfg_limit (cfg_limit),
    .lim_o     (lim),
    .en_o      (en)
  );

  assign cmd_counted = cmd_vld && dthr_pkg::counts_against_budget(cmd_kind);

  for (genvar g = 0; g < NUM_DIMMS; g++) begin : g_dimm
    assign hit[g] = cmd_counted && (cmd_dimm == SEL_W'(g));

    dthr_dimm_ctr #(.LIM_W(LIM_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_i),
      .hit     (hit[g]),
      .win_end (win_end),
      .limit   (lim[g]),
      .en      (en[g]),
      .cnt_o   (cnt_q[g]),
      .hold_o  (dimm_hold[g])
    );
  end

endmodule

// File: rtl/dthr_checker.sv
module dthr_checker #(
  parameter int NUM_DIMMS = 3,
  parameter int LIM_W     = 12,
  parameter int SEL_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_i,
  input  logic                            win_end,
  input  logic                            cmd_vld,
  input  logic [2:0]                      cmd_kind,
  input  logic [SEL_W-1:0]                cmd_dimm,
  input  logic                            cfg_we,
  input  logic [NUM_DIMMS-1:0][LIM_W-1:0] cnt,
  input  logic [NUM_DIMMS-1:0][LIM_W-1:0] lim,
  input  logic [NUM_DIMMS-1:0]            en,
  input  logic [NUM_DIMMS-1:0]            hold
);

  // R5
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    win_end |=> (cnt == '0));

  // R2
  uncounted_kind_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!win_end && !(cmd_vld && dthr_pkg::counts_against_budget(cmd_kind))) |=> $stable(cnt));

  // R3
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!win_end && (32'(cmd_dimm) >= NUM_DIMMS)) |=> $stable(cnt));

  for (genvar g = 0; g < NUM_DIMMS; g++) begin : g_chk
    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
      ((cnt[g] == '1) && !win_end) |=> (cnt[g] == '1));

    // R6
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
      !en[g] |-> !hold[g]);

    // R8
    zero_budget_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (en[g] && (lim[g] == '0)) |-> hold[g]);

    // R4
    hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
      $rose(hold[g]) |-> ($past(cfg_we) || (cnt[g] != $past(cnt[g]))));
  end

endmodule

bind dimm_rate_throttle dthr_checker #(
  .NUM_DIMMS (NUM_DIMMS),
  .LIM_W     (LIM_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .win_end  (win_end),
  .cmd_vld  (cmd_vld),
  .cmd_kind (cmd_kind),
  .cmd_dimm (cmd_dimm),
  .cfg_we   (cfg_we),
  .cnt      (cnt_q),
  .lim      (lim),
  .en       (en),
  .hold     (dimm_hold)
);

// File: tb/sim_dimm_rate_throttle.sv
`timescale 1ns/1ps
module sim_dimm_rate_throttle;

  localparam int ND  = 3;
  localparam int CYC = 40;
  localparam int LW  = 4;
  localparam int SW  = 2;

  logic          clk;
  logic          rst_n;
  logic          cmd_vld;
  logic [2:0]    cmd_kind;
  logic [SW-1:0] cmd_dimm;
  logic          cfg_we;
  logic [SW-1:0] cfg_sel;
  logic          cfg_en;
  logic [LW-1:0] cfg_limit;
  logic [ND-1:0] dimm_hold;

  int total = 0;
  int bad   = 0;
  int ecount;

  dimm_rate_throttle #(.NUM_DIMMS(ND), .CYC_PER_US(CYC), .LIM_W(LW), .SEL_W(SW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld   (cmd_vld),
    .cmd_kind  (cmd_kind),
    .cmd_dimm  (cmd_dimm),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_en    (cfg_en),
    .cfg_limit (cfg_limit),
    .dimm_hold (dimm_hold)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Edges since reset release; window position = (ecount-2) mod CYC (R1 timing).
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  function automatic int cur_pos();
    return (ecount - 2) % CYC;
  endfunction

  // Table entry: {vld, dimm[1:0], kind[2:0], expected hold[2:0]}
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 2'd0, 3'd1, 3'b000},  // R2 activate counts
    {1'b1, 2'd0, 3'd2, 3'b000},  // R2 read counts
    {1'b1, 2'd0, 3'd4, 3'b000},  // R2 precharge ignored
    {1'b1, 2'd1, 3'd5, 3'b000},  // R2 refresh ignored
    {1'b1, 2'd1, 3'd3, 3'b000},  // R2 write counts
    {1'b0, 2'd1, 3'd1, 3'b000},  // R2 no strobe
    {1'b1, 2'd1, 3'd1, 3'b010},  // R4 DIMM1 reaches 2
    {1'b1, 2'd0, 3'd3, 3'b011},  // R4 DIMM0 reaches 3
    {1'b1, 2'd3, 3'd1, 3'b011},  // R3 index out of range
    {1'b1, 2'd2, 3'd2, 3'b011},  // R3 DIMM2 alone
    {1'b1, 2'd2, 3'd6, 3'b011},  // R2 kind 6 ignored
    {1'b1, 2'd2, 3'd7, 3'b011}   // R2 kind 7 ignored
  };

  task automatic chk(input string tag, input logic [ND-1:0] act, input logic [ND-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: hold actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic align(input int p);
    step();
    while (cur_pos() != p) step();
  endtask

  task automatic idle();
    cmd_vld = 1'b0;
    cfg_we  = 1'b0;
  endtask

  task automatic issue(input logic [SW-1:0] d, input logic [2:0] k);
    cmd_vld  = 1'b1;
    cmd_dimm = d;
    cmd_kind = k;
    step();
    cmd_vld  = 1'b0;
  endtask

  task automatic wr_cfg(input logic [SW-1:0] s, input logic e, input logic [LW-1:0] l);
    cfg_we    = 1'b1;
    cfg_sel   = s;
    cfg_en    = e;
    cfg_limit = l;
    step();
    cfg_we    = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    cmd_kind  = 3'd0;
    cmd_dimm  = '0;
    cfg_sel   = '0;
    cfg_en    = 1'b0;
    cfg_limit = '0;
    repeat (3) @(posedge clk);
    step();
    chk("R1 reset hold", dimm_hold, 3'b000);
    rst_n = 1'b1;

    // R1/R4 default budget all ones, R9 saturation
    align(1);
    for (int j = 1; j <= 20; j++) begin
      issue(2'd2, 3'd1);
      if (j == 14) chk("R1 default budget below", dimm_hold, 3'b000);
      if (j == 15) chk("R4 default budget reached", dimm_hold, 3'b100);
      if (j == 16) chk("R9 no wrap", dimm_hold, 3'b100);
      if (j == 20) chk("R9 saturated", dimm_hold, 3'b100);
    end
    align(0);
    chk("R5 window clears", dimm_hold, 3'b000);

    // Table walk
    wr_cfg(2'd0, 1'b1, 4'd3);
    wr_cfg(2'd1, 1'b1, 4'd2);
    align(1);
    for (int i = 0; i < 12; i++) begin
      cmd_vld  = VEC[i][8];
      cmd_dimm = VEC[i][7:6];
      cmd_kind = VEC[i][5:3];
      step();
      cmd_vld  = 1'b0;
      chk($sformatf("R2/R3/R4 vector %0d", i), dimm_hold, VEC[i][2:0]);
    end
    align(0);
    chk("R5 first cycle of window", dimm_hold, 3'b000);

    // R10 / R8
    wr_cfg(2'd3, 1'b1, 4'd0);
    chk("R10 out-of-range select", dimm_hold, 3'b000);
    wr_cfg(2'd1, 1'b1, 4'd0);
    chk("R8 zero budget R10 slot", dimm_hold, 3'b010);
    align(0);
    chk("R8 zero budget across window", dimm_hold, 3'b010);

    // R6
    wr_cfg(2'd1, 1'b0, 4'd0);
    chk("R6 disabled", dimm_hold, 3'b000);
    issue(2'd1, 3'd1);
    issue(2'd1, 3'd2);
    issue(2'd1, 3'd3);
    chk("R6 disabled with traffic", dimm_hold, 3'b000);
    wr_cfg(2'd1, 1'b1, 4'd2);
    chk("R6 re-enable over budget", dimm_hold, 3'b010);
    wr_cfg(2'd1, 1'b1, 4'd15);
    chk("R10 restore", dimm_hold, 3'b000);

    // R7
    align(1);
    wr_cfg(2'd0, 1'b1, 4'd5);
    issue(2'd0, 3'd1);
    issue(2'd0, 3'd2);
    issue(2'd0, 3'd3);
    chk("R7 below budget", dimm_hold, 3'b000);
    wr_cfg(2'd0, 1'b1, 4'd2);
    chk("R7 budget lowered", dimm_hold, 3'b001);
    align(CYC - 1);
    chk("R7 held to window end", dimm_hold, 3'b001);
    align(0);
    chk("R7 released at boundary", dimm_hold, 3'b000);

    // R5 last-cycle command
    wr_cfg(2'd0, 1'b1, 4'd1);
    align(CYC - 1);
    issue(2'd0, 3'd1);
    chk("R5 last-cycle command dropped", dimm_hold, 3'b000);
    step();
    chk("R5 not carried", dimm_hold, 3'b000);
    issue(2'd0, 3'd1);
    chk("R4 budget one", dimm_hold, 3'b001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule